// File: doc/BRIEF.md
# Channel Source Connection Controller

This block owns the connection state of the sending end of a point-to-point channel. The host asks for a connection with a level request and can cancel it abruptly with a reset command. The far end answers on an asynchronous connect line. The block drives a request line towards the far end, reports the synchronized connect status back to the host, and raises a link-up flag that lets a burst sequencer run only while the connection is established.

Teardown has two paths. In the graceful path the host drops its request. The block withdraws its request line, enters the terminating state, and waits there only for the far end to drop connect. In the abrupt path the reset command forces the initialisation state. That state is left only when the far end has dropped connect and the host has also dropped its request.

States: INIT (after reset or a reset command, request low), IDLE (no connection, request low), WAIT (request raised, waiting for connect), CONN (connection established), TERM (request withdrawn, waiting for connect to fall). Transitions: INIT→IDLE when connect and host request are both low. IDLE→WAIT on host request. WAIT→IDLE when the host request is withdrawn. WAIT→CONN when the synchronized connect is high. CONN→TERM when the host request falls or connect falls. TERM→IDLE when connect is low. Any state→INIT on the reset command, which has priority over every other transition.

Top module: `chan_link_ctrl`

## Requirements
- R1: After reset `link_request`, `conn_status` and `link_up` are all 0, and the block is in INIT.
- R2: INIT is left for IDLE only when the synchronized connect and `host_conn_req` are both 0. While either is 1, `link_request` stays 0 even if the host request is high.
- R3: In IDLE, `host_conn_req` = 1 raises `link_request` on the next clock edge.
- R4: In WAIT, a synchronized connect of 1 moves the block to CONN and sets `link_up`. `link_up` rises on the third rising edge after `remote_connect` rises, and it is 1 only in CONN.
- R5: In WAIT, dropping `host_conn_req` before connect arrives returns the block to IDLE with `link_request` = 0.
- R6: In CONN, `host_conn_req` = 0 clears `link_request` and `link_up` on the next edge and enters TERM.
- R7: TERM is held while the synchronized connect is 1, and `link_request` stays 0 there even if the host request returns. When connect falls the block goes to IDLE, from where a pending host request raises `link_request` again.
- R8: `host_abort` = 1 in any state clears `link_request` and `link_up` on the next edge and forces INIT.
- R9: `conn_status` equals `remote_connect` delayed through two flops, so it follows the input on the second rising edge.
- R10: In CONN, a fall of the synchronized connect enters TERM, which then passes to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_conn_req | input | 1 | Host connection request (level, synchronous) |
| host_abort | input | 1 | Host reset command forcing INIT (synchronous) |
| remote_connect | input | 1 | Connect line from the far end (asynchronous) |
| link_request | output | 1 | Request line to the far end |
| conn_status | output | 1 | Synchronized connect status for the host |
| link_up | output | 1 | Connection established, enables the burst sequencer |

## Verification
The assertions assume that `host_conn_req` and `host_abort` are synchronous to `clk` and that the far end raises connect only while a request is pending. They make no assumption about connect timing, because it is sampled only after the synchronizer. The bench changes every input on the falling edge. It holds each input pattern long enough for the synchronizer and the state register to settle before it samples. Separate directed steps measure the exact two-edge and three-edge latencies and the one-edge response to the reset command.

// File: rtl/chan_link_pkg.sv
package chan_link_pkg;

    typedef enum logic [2:0] {
        LS_INIT = 3'd0,
        LS_IDLE = 3'd1,
        LS_WAIT = 3'd2,
        LS_CONN = 3'd3,
        LS_TERM = 3'd4
    } link_state_t;

    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/chan_link_sync.sv
module chan_link_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q_sync = chain[LAST];

    initial begin
        assert (STAGES >= chan_link_pkg::MIN_SYNC_STAGES)
            else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/chan_link_fsm.sv
module chan_link_fsm
    import chan_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic abort,
    input  logic conn_seen,
    output logic link_request,
    output logic link_up
);
    link_state_t cur_st, nxt_st;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= LS_INIT;
        else        cur_st <= nxt_st;
    end

    // transition logic, reset command has priority
    always_comb begin
        nxt_st = cur_st;
        if (abort) begin
            nxt_st = LS_INIT;
        end else begin
            unique case (cur_st)
                LS_INIT: if (!conn_seen && !host_req) nxt_st = LS_IDLE;
                LS_IDLE: if (host_req)                nxt_st = LS_WAIT;
                LS_WAIT: begin
                    if (!host_req)      nxt_st = LS_IDLE;
                    else if (conn_seen) nxt_st = LS_CONN;
                end
                LS_CONN: if (!host_req || !conn_seen) nxt_st = LS_TERM;
                LS_TERM: if (!conn_seen)              nxt_st = LS_IDLE;
                default:                              nxt_st = LS_INIT;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        link_request = 1'b0;
        link_up      = 1'b0;
        unique case (cur_st)
            LS_WAIT: link_request = 1'b1;
            LS_CONN: begin
                link_request = 1'b1;
                link_up      = 1'b1;
            end
            default: ;
        endcase
    end

    assert_abort_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!link_request && !link_up));

    assert_graceful_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !host_req) |=> !link_request);

    assert_term_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == LS_TERM && conn_seen && !abort) |=> (cur_st == LS_TERM && !link_request));

    assert_init_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == LS_INIT && (conn_seen || host_req)) |=> (cur_st == LS_INIT));

    assert_up_needs_connect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(conn_seen));

    assert_idle_raises_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == LS_IDLE && host_req && !abort) |=> link_request);
endmodule

// File: rtl/chan_link_ctrl.sv
module chan_link_ctrl #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_conn_req,
    input  logic host_abort,
    input  logic remote_connect,
    output logic link_request,
    output logic conn_status,
    output logic link_up
);
    logic conn_sync;

    chan_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (remote_connect),
        .q_sync  (conn_sync)
    );

    chan_link_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_conn_req),
        .abort        (host_abort),
        .conn_seen    (conn_sync),
        .link_request (link_request),
        .link_up      (link_up)
    );

    assign conn_status = conn_sync;

    // R10: losing connect while up drops the link on the next edge
    assert_remote_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !conn_sync) |=> !link_up);
endmodule

// File: tb/chan_link_ctrl_bench.sv
module chan_link_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 6;
    localparam int NVEC       = 17;

    // fields: [9:6] req tag, [5] req, [4] abort, [3] connect, [2] exp request, [1] exp status, [0] exp up
    localparam logic [9:0] VEC [NVEC] = '{
        {4'd2,  3'b000, 3'b000},  // R2 INIT -> IDLE
        {4'd3,  3'b100, 3'b100},  // R3 IDLE -> WAIT
        {4'd4,  3'b101, 3'b111},  // R4 WAIT -> CONN
        {4'd6,  3'b001, 3'b010},  // R6 CONN -> TERM
        {4'd7,  3'b101, 3'b010},  // R7 TERM held, request ignored
        {4'd7,  3'b100, 3'b100},  // R7 TERM -> IDLE -> WAIT
        {4'd5,  3'b000, 3'b000},  // R5 WAIT -> IDLE
        {4'd4,  3'b101, 3'b111},  // R4 again to CONN
        {4'd10, 3'b100, 3'b100},  // R10 remote drop, back to WAIT
        {4'd4,  3'b101, 3'b111},  // R4 CONN
        {4'd8,  3'b111, 3'b010},  // R8 abort from CONN
        {4'd2,  3'b101, 3'b010},  // R2 INIT held, both high
        {4'd2,  3'b100, 3'b000},  // R2 INIT held, request high
        {4'd2,  3'b000, 3'b000},  // R2 INIT -> IDLE
        {4'd3,  3'b100, 3'b100},  // R3 IDLE -> WAIT
        {4'd8,  3'b110, 3'b000},  // R8 abort from WAIT
        {4'd2,  3'b000, 3'b000}   // R2 INIT -> IDLE
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_conn_req = 1'b0;
    logic host_abort = 1'b0;
    logic remote_connect = 1'b0;
    logic link_request, conn_status, link_up;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_link_ctrl u_chan_link_ctrl (
        .clk(clk), .rst_n(rst_n), .host_conn_req(host_conn_req),
        .host_abort(host_abort), .remote_connect(remote_connect),
        .link_request(link_request), .conn_status(conn_status), .link_up(link_up)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {request,status,up} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        edges(2);
        check("R1 reset", {link_request, conn_status, link_up}, 3'b000);
        rst_n = 1'b1;
        edges(1);
        check("R1 after release", {link_request, conn_status, link_up}, 3'b000);

        for (int i = 0; i < NVEC; i++) begin
            host_conn_req  = VEC[i][5];
            host_abort     = VEC[i][4];
            remote_connect = VEC[i][3];
            edges(HOLD);
            check($sformatf("R%0d vector %0d", VEC[i][9:6], i),
                  {link_request, conn_status, link_up}, VEC[i][2:0]);
        end
        host_abort = 1'b0;

        // now IDLE, request low; R3 one-edge response
        host_conn_req = 1'b1;
        edges(1);
        check("R3 one edge", {link_request, conn_status, link_up}, 3'b100);

        // R9 and R4 exact latency
        remote_connect = 1'b1;
        edges(1);
        check("R9 after one edge", {link_request, conn_status, link_up}, 3'b100);
        edges(1);
        check("R9 after two edges", {link_request, conn_status, link_up}, 3'b110);
        edges(1);
        check("R4 up on third edge", {link_request, conn_status, link_up}, 3'b111);

        // R6 one-edge graceful drop
        host_conn_req = 1'b0;
        edges(1);
        check("R6 one edge", {link_request, conn_status, link_up}, 3'b010);
        remote_connect = 1'b0;
        edges(HOLD);
        check("R7 TERM -> IDLE", {link_request, conn_status, link_up}, 3'b000);

        // R8 single-cycle abort pulse while connected
        host_conn_req = 1'b1;
        remote_connect = 1'b1;
        edges(HOLD);
        check("R4 reconnect", {link_request, conn_status, link_up}, 3'b111);
        host_abort = 1'b1;
        edges(1);
        host_abort = 1'b0;
        check("R8 one edge", {link_request, conn_status, link_up}, 3'b010);
        remote_connect = 1'b0;
        edges(HOLD);
        check("R2 INIT while request high", {link_request, conn_status, link_up}, 3'b000);
        host_conn_req = 1'b0;
        edges(2);
        host_conn_req = 1'b1;
        edges(2);
        check("R2 left INIT", {link_request, conn_status, link_up}, 3'b100);

        // R1 asynchronous reset mid-connection
        remote_connect = 1'b1;
        edges(HOLD);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", {link_request, conn_status, link_up}, 3'b000);

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule